// File: doc/BRIEF.md
# Configuration Space Address/Data Bridge

This block sits between a host register bus and a configuration fabric. Software reaches configuration space through two narrow host ports. The first is a 32-bit pointer port. A full-word write stores a pointer that holds an enable flag, a bus number, a device/function number and a register offset. The second is a 4-byte data window. Each access to the window becomes one configuration request, aimed at the target the pointer names. The low bits of the window address select the byte lane inside the register.

The fabric answers in the same cycle. It reports whether a device sits at the target, whether function 0 of that device exists, and whether the target was hot-added, and it returns read data. When the target cannot be used, the bridge turns the access into a silent drop for a write or an all-ones word for a read. Reads on either host port return data one cycle after the strobe. The read-data register holds its value until the next read on that port.

Top module: `cfgb_bridge`

## Requirements
- R1: A pointer-port write loads the pointer only when `ptr_off` is 0 and `ptr_len` is 4. Any other write to the pointer port leaves the pointer unchanged.
- R2: A pointer-port read returns the whole 32-bit pointer on `ptr_rdata` one cycle after the strobe, whatever `ptr_len` is. `ptr_rdata` holds between reads.
- R3: After reset the pointer is zero, so bit 31 (enable) is clear. Both read-data outputs are zero.
- R4: While pointer bit 31 is 0, a window access raises no request (`cq_valid` stays 0), and a window read returns 32'hFFFF_FFFF.
- R5: While bit 31 is 1, a window strobe raises `cq_valid` for that same cycle only. The request fields are: `cq_bus` = pointer[23:16], `cq_devfn` = pointer[15:8], `cq_reg` = pointer[7:0] bitwise-OR `win_off`, `cq_we` = `win_we` and `cq_wdata` = `win_wdata`.
- R6: `cq_len` is the smaller of the requested length (values above 4 count as 4) and 256 minus `cq_reg`.
- R7: If `cr_present` is 0 during a request, `cq_commit` stays 0 for a write, and a read returns 32'hFFFF_FFFF.
- R8: A target is hidden when three things hold together: `cr_hotplug` is 1, the function field `cq_devfn[2:0]` is non-zero, and `cr_fn0_present` is 0. A hidden write does not commit and a hidden read returns all ones. Function 0 is never hidden.
- R9: A read that reaches a visible target returns `cr_rdata` on `win_rdata` one cycle after the strobe. Only its low `cq_len` bytes are kept, right-justified, and the upper bytes are zero.
- R10: `cq_commit` is 1 exactly when a write request goes to a present, visible target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_stb | input | 1 | Pointer-port access strobe |
| ptr_we | input | 1 | Pointer-port write (1) or read (0) |
| ptr_off | input | 2 | Byte offset within the pointer port |
| ptr_len | input | 3 | Access length in bytes |
| ptr_wdata | input | 32 | Pointer write data |
| ptr_rdata | output | 32 | Pointer read data, one cycle after the strobe |
| win_stb | input | 1 | Data-window access strobe |
| win_we | input | 1 | Data-window write (1) or read (0) |
| win_off | input | 2 | Byte lane within the data window |
| win_len | input | 3 | Access length in bytes |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Window read data, one cycle after the strobe |
| cq_valid | output | 1 | Single-cycle configuration request |
| cq_we | output | 1 | Request is a write |
| cq_bus | output | 8 | Target bus number |
| cq_devfn | output | 8 | Target device/function |
| cq_reg | output | 8 | Target register offset |
| cq_len | output | 3 | Clipped length in bytes |
| cq_wdata | output | 32 | Write data |
| cq_commit | output | 1 | Write may take effect at the target |
| cr_present | input | 1 | A device answers at the target |
| cr_fn0_present | input | 1 | Function 0 of the target device exists |
| cr_hotplug | input | 1 | Target was hot-added |
| cr_rdata | input | 32 | Read data from the target |

## Verification
A corrupted pointer appears at the ports in the same cycle as the next window strobe. It shows as a wrong bus, devfn or register field on the request, or as a request that should be blocked. It also appears one cycle after any pointer read. A faulty length clip or lane mask shows in `cq_len` at once and in `win_rdata` one cycle later. A wrong presence or hide decision shows as a stray or missing `cq_commit` in the request cycle, or as an all-ones word in place of data. The bench compares every output against a behavioural model on every clock, so each of these faults is reported within one cycle of the access that exposes it.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
   localparam int CFG_SPACE = 256;
   localparam int REG_W     = 8;

   typedef struct packed {
      logic [7:0]       bus;
      logic [7:0]       devfn;
      logic [REG_W-1:0] regno;
   } cfgb_target_t;
endpackage

// File: rtl/cfgb_latch.sv
module cfgb_latch #(
   parameter int DATA_W   = 32,
   parameter int LEN_W    = 3,
   parameter int OFF_W    = 2,
   parameter int FULL_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic              we,
   input  logic [OFF_W-1:0]  off,
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] latch_q,
   output logic [DATA_W-1:0] rdata_q
);
   logic full_wr;
   logic rd;

   // only a whole-word access at offset zero reaches the pointer
   assign full_wr = stb & we & (off == '0) & (len == LEN_W'(FULL_LEN));
   assign rd      = stb & ~we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         latch_q <= '0;
         rdata_q <= '0;
      end else begin
         if (full_wr) latch_q <= wdata;
         if (rd)      rdata_q <= latch_q;
      end
   end
endmodule

// File: rtl/cfgb_decode.sv
module cfgb_decode
   import cfgb_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LEN_W   = 3,
   parameter int OFF_W   = 2,
   parameter int MAX_LEN = 4
) (
   input  logic [DATA_W-1:0] latch,
   input  logic [OFF_W-1:0]  off,
   input  logic [LEN_W-1:0]  len,
   output cfgb_target_t      tgt,
   output logic [LEN_W-1:0]  eff_len
);
   localparam int ROOM_W = REG_W + 1;

   logic [LEN_W-1:0]  req_len;
   logic [ROOM_W-1:0] room;

   always_comb begin
      tgt.bus   = latch[23:16];
      tgt.devfn = latch[15:8];
      tgt.regno = latch[REG_W-1:0] | REG_W'(off);
      req_len   = (len > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len;
      room      = ROOM_W'(CFG_SPACE) - {1'b0, tgt.regno};
      eff_len   = (ROOM_W'(req_len) > room) ? room[LEN_W-1:0] : req_len;
   end
endmodule

// File: rtl/cfgb_resp.sv
module cfgb_resp #(
   parameter int DATA_BYTES = 4,
   parameter int LEN_W      = 3,
   parameter int FUNC_W     = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rd_stb,
   input  logic                    enable,
   input  logic                    present,
   input  logic                    fn0_present,
   input  logic                    hotplug,
   input  logic [7:0]              devfn,
   input  logic [LEN_W-1:0]        eff_len,
   input  logic [8*DATA_BYTES-1:0] rs_rdata,
   output logic                    visible,
   output logic [8*DATA_BYTES-1:0] rdata_q
);
   localparam int DATA_W = 8 * DATA_BYTES;

   logic              hidden;
   logic [DATA_W-1:0] lane_mask;
   logic [DATA_W-1:0] merged;

   assign hidden  = hotplug & (devfn[FUNC_W-1:0] != '0) & ~fn0_present;
   assign visible = enable & present & ~hidden;

   for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
      assign lane_mask[8*g +: 8] = {8{eff_len > LEN_W'(g)}};
   end

   assign merged = visible ? (rs_rdata & lane_mask) : '1;

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_stb) rdata_q <= merged;
   end
endmodule

// File: rtl/cfgb_bridge.sv
module cfgb_bridge
   import cfgb_pkg::*;
#(
   parameter int DATA_BYTES = 4,
   parameter int LEN_W      = 3,
   parameter int FUNC_W     = 3,
   parameter int EN_BIT     = 31
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ptr_stb,
   input  logic                    ptr_we,
   input  logic [1:0]              ptr_off,
   input  logic [LEN_W-1:0]        ptr_len,
   input  logic [8*DATA_BYTES-1:0] ptr_wdata,
   output logic [8*DATA_BYTES-1:0] ptr_rdata,
   input  logic                    win_stb,
   input  logic                    win_we,
   input  logic [1:0]              win_off,
   input  logic [LEN_W-1:0]        win_len,
   input  logic [8*DATA_BYTES-1:0] win_wdata,
   output logic [8*DATA_BYTES-1:0] win_rdata,
   output logic                    cq_valid,
   output logic                    cq_we,
   output logic [7:0]              cq_bus,
   output logic [7:0]              cq_devfn,
   output logic [7:0]              cq_reg,
   output logic [LEN_W-1:0]        cq_len,
   output logic [8*DATA_BYTES-1:0] cq_wdata,
   output logic                    cq_commit,
   input  logic                    cr_present,
   input  logic                    cr_fn0_present,
   input  logic                    cr_hotplug,
   input  logic [8*DATA_BYTES-1:0] cr_rdata
);
   localparam int DATA_W = 8 * DATA_BYTES;
   localparam int OFF_W  = $clog2(DATA_BYTES);

   if (DATA_BYTES != 4 || EN_BIT < 24 || EN_BIT >= DATA_W ||
       (1 << LEN_W) <= DATA_BYTES || FUNC_W < 1 || FUNC_W > 8) begin : g_bad_params
      $error("cfgb_bridge: unsupported parameter set");
   end

   logic [DATA_W-1:0] latch_q;
   logic              enable;
   cfgb_target_t      tgt;
   logic [LEN_W-1:0]  eff_len;
   logic              visible;

   cfgb_latch #(.DATA_W(DATA_W), .LEN_W(LEN_W), .OFF_W(OFF_W), .FULL_LEN(DATA_BYTES)) u_latch (
      .clk(clk), .rst_n(rst_n), .stb(ptr_stb), .we(ptr_we), .off(ptr_off[OFF_W-1:0]),
      .len(ptr_len), .wdata(ptr_wdata), .latch_q(latch_q), .rdata_q(ptr_rdata)
   );

   assign enable = latch_q[EN_BIT];

   cfgb_decode #(.DATA_W(DATA_W), .LEN_W(LEN_W), .OFF_W(OFF_W), .MAX_LEN(DATA_BYTES)) u_decode (
      .latch(latch_q), .off(win_off[OFF_W-1:0]), .len(win_len), .tgt(tgt), .eff_len(eff_len)
   );

   cfgb_resp #(.DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W), .FUNC_W(FUNC_W)) u_resp (
      .clk(clk), .rst_n(rst_n), .rd_stb(win_stb & ~win_we), .enable(enable),
      .present(cr_present), .fn0_present(cr_fn0_present), .hotplug(cr_hotplug),
      .devfn(tgt.devfn), .eff_len(eff_len), .rs_rdata(cr_rdata),
      .visible(visible), .rdata_q(win_rdata)
   );

   assign cq_valid  = win_stb & enable;
   assign cq_we     = win_we;
   assign cq_bus    = tgt.bus;
   assign cq_devfn  = tgt.devfn;
   assign cq_reg    = tgt.regno;
   assign cq_len    = eff_len;
   assign cq_wdata  = win_wdata;
   assign cq_commit = cq_valid & win_we & visible;
endmodule

// File: rtl/cfgb_bridge_chk.sv
module cfgb_bridge_chk #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 3,
   parameter int FUNC_W = 3,
   parameter int EN_BIT = 31
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ptr_stb,
   input logic              ptr_we,
   input logic [1:0]        ptr_off,
   input logic [LEN_W-1:0]  ptr_len,
   input logic              win_stb,
   input logic              win_we,
   input logic [LEN_W-1:0]  win_len,
   input logic [DATA_W-1:0] win_rdata,
   input logic              cq_valid,
   input logic              cq_we,
   input logic [7:0]        cq_devfn,
   input logic [7:0]        cq_reg,
   input logic [LEN_W-1:0]  cq_len,
   input logic              cq_commit,
   input logic              cr_present,
   input logic              cr_fn0_present,
   input logic              cr_hotplug,
   input logic [DATA_W-1:0] latch
);
   p_partial_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_stb && ptr_we && (ptr_off != 2'd0 || ptr_len != LEN_W'(4))) |=> $stable(latch));

   p_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (latch == '0));

   p_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !latch[EN_BIT] |-> !cq_valid);

   p_off_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (win_stb && !win_we && !latch[EN_BIT]) |=> (win_rdata == '1));

   p_len_fit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cq_valid |-> ((9'(cq_reg) + 9'(cq_len)) <= 9'd256 && cq_len <= win_len && cq_len <= LEN_W'(4)));

   p_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cq_valid && !cr_present) |-> !cq_commit);

   p_hide_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cq_valid && cr_hotplug && cq_devfn[FUNC_W-1:0] != '0 && !cr_fn0_present) |-> !cq_commit);

   p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cq_valid && !cq_we && cr_present && !cr_hotplug && cq_len == LEN_W'(1))
         |=> (win_rdata[DATA_W-1:8] == '0));

   p_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cq_commit |-> (cq_valid && cq_we && cr_present));
endmodule

bind cfgb_bridge cfgb_bridge_chk #(
   .DATA_W(8 * DATA_BYTES), .LEN_W(LEN_W), .FUNC_W(FUNC_W), .EN_BIT(EN_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ptr_stb(ptr_stb), .ptr_we(ptr_we), .ptr_off(ptr_off),
   .ptr_len(ptr_len), .win_stb(win_stb), .win_we(win_we), .win_len(win_len),
   .win_rdata(win_rdata), .cq_valid(cq_valid), .cq_we(cq_we), .cq_devfn(cq_devfn),
   .cq_reg(cq_reg), .cq_len(cq_len), .cq_commit(cq_commit), .cr_present(cr_present),
   .cr_fn0_present(cr_fn0_present), .cr_hotplug(cr_hotplug), .latch(latch_q)
);

// File: tb/tb_cfgb_bridge.sv
`timescale 1ns/1ps
module tb_cfgb_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_stb = 0, ptr_we = 0;
   logic [1:0]  ptr_off = 0;
   logic [2:0]  ptr_len = 0;
   logic [31:0] ptr_wdata = 0;
   logic [31:0] ptr_rdata;
   logic        win_stb = 0, win_we = 0;
   logic [1:0]  win_off = 0;
   logic [2:0]  win_len = 0;
   logic [31:0] win_wdata = 0;
   logic [31:0] win_rdata;
   logic        cq_valid, cq_we, cq_commit;
   logic [7:0]  cq_bus, cq_devfn, cq_reg;
   logic [2:0]  cq_len;
   logic [31:0] cq_wdata;
   logic        cr_present = 0, cr_fn0_present = 0, cr_hotplug = 0;
   logic [31:0] cr_rdata = 0;

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   string cur_req = "R3";

   // reference state
   logic [31:0] m_ptr = 0, m_ptr_rd = 0, m_win_rd = 0;

   always #10 clk = ~clk;

   cfgb_bridge dut (
      .clk(clk), .rst_n(rst_n),
      .ptr_stb(ptr_stb), .ptr_we(ptr_we), .ptr_off(ptr_off), .ptr_len(ptr_len),
      .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata),
      .win_stb(win_stb), .win_we(win_we), .win_off(win_off), .win_len(win_len),
      .win_wdata(win_wdata), .win_rdata(win_rdata),
      .cq_valid(cq_valid), .cq_we(cq_we), .cq_bus(cq_bus), .cq_devfn(cq_devfn),
      .cq_reg(cq_reg), .cq_len(cq_len), .cq_wdata(cq_wdata), .cq_commit(cq_commit),
      .cr_present(cr_present), .cr_fn0_present(cr_fn0_present), .cr_hotplug(cr_hotplug),
      .cr_rdata(cr_rdata)
   );

   function automatic int f_len(logic [31:0] p, logic [1:0] off, logic [2:0] len);
      int r, l;
      r = int'(p[7:0] | {6'd0, off});
      l = (len > 3'd4) ? 4 : int'(len);
      if (l > 256 - r) l = 256 - r;
      return l;
   endfunction

   function automatic logic [31:0] f_read(logic [31:0] p, logic [1:0] off, logic [2:0] len,
                                          logic pres, logic fn0, logic hp, logic [31:0] d);
      logic [63:0] m;
      if (!p[31] || !pres) return 32'hFFFF_FFFF;
      if (hp && p[10:8] != 3'd0 && !fn0) return 32'hFFFF_FFFF;
      m = (64'd1 << (8 * f_len(p, off, len))) - 64'd1;
      return d & m[31:0];
   endfunction

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   // model update on the same edge the design samples
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ptr = 0; m_ptr_rd = 0; m_win_rd = 0;
      end else begin
         if (ptr_stb && !ptr_we) m_ptr_rd = m_ptr;
         if (win_stb && !win_we)
            m_win_rd = f_read(m_ptr, win_off, win_len, cr_present, cr_fn0_present, cr_hotplug, cr_rdata);
         if (ptr_stb && ptr_we && ptr_off == 2'd0 && ptr_len == 3'd4) m_ptr = ptr_wdata;
      end
   end

   // compare every output every clock, away from the active edge
   always @(negedge clk) begin
      logic ev, vis;
      if (rst_n && !done) begin
         ev  = win_stb && m_ptr[31];
         vis = cr_present && !(cr_hotplug && m_ptr[10:8] != 3'd0 && !cr_fn0_present);
         chk("ptr_rdata", ptr_rdata, m_ptr_rd);
         chk("win_rdata", win_rdata, m_win_rd);
         chk("cq_valid", 32'(cq_valid), 32'(ev));
         chk("cq_commit", 32'(cq_commit), 32'(ev && win_we && vis));
         if (ev) begin
            chk("cq_bus", 32'(cq_bus), 32'(m_ptr[23:16]));
            chk("cq_devfn", 32'(cq_devfn), 32'(m_ptr[15:8]));
            chk("cq_reg", 32'(cq_reg), 32'(m_ptr[7:0] | {6'd0, win_off}));
            chk("cq_len", 32'(cq_len), 32'(f_len(m_ptr, win_off, win_len)));
            chk("cq_we", 32'(cq_we), 32'(win_we));
            chk("cq_wdata", cq_wdata, win_wdata);
         end
      end
   end

   task automatic idle();
      @(posedge clk); #1;
      ptr_stb = 0; win_stb = 0;
   endtask

   task automatic ptr_op(logic we, logic [1:0] off, logic [2:0] len, logic [31:0] d);
      @(posedge clk); #1;
      win_stb = 0;
      ptr_stb = 1; ptr_we = we; ptr_off = off; ptr_len = len; ptr_wdata = d;
   endtask

   task automatic win_op(logic we, logic [1:0] off, logic [2:0] len, logic [31:0] wd,
                         logic pres, logic fn0, logic hp, logic [31:0] rd);
      @(posedge clk); #1;
      ptr_stb = 0;
      win_stb = 1; win_we = we; win_off = off; win_len = len; win_wdata = wd;
      cr_present = pres; cr_fn0_present = fn0; cr_hotplug = hp; cr_rdata = rd;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      cur_req = "R3";
      chk("reset ptr_rdata", ptr_rdata, 32'h0);
      chk("reset win_rdata", win_rdata, 32'h0);
      ptr_op(0, 0, 4, 0); idle();
      win_op(0, 0, 4, 0, 1, 1, 0, 32'h1234_5678); idle();

      cur_req = "R1";
      ptr_op(1, 1, 4, 32'h8111_1111);
      ptr_op(1, 0, 2, 32'h8222_2222);
      ptr_op(1, 0, 1, 32'h8333_3333);
      ptr_op(0, 0, 4, 0); idle();
      ptr_op(1, 0, 4, 32'h0012_3400);

      cur_req = "R2";
      ptr_op(0, 2, 1, 0);
      ptr_op(0, 0, 2, 0); idle(); idle();

      cur_req = "R4";
      win_op(0, 0, 4, 0, 1, 1, 0, 32'hCAFE_F00D);
      win_op(1, 1, 2, 32'hDEAD_BEEF, 1, 1, 0, 0); idle();

      cur_req = "R5";
      ptr_op(1, 0, 4, 32'h8003_1A05);
      for (int o = 0; o < 4; o++) win_op(1, 2'(o), 1, 32'hA5A5_0000 + o, 1, 1, 0, 0);
      win_op(0, 3, 4, 0, 1, 1, 0, 32'h0BAD_CAFE); idle();

      cur_req = "R9";
      win_op(0, 0, 1, 0, 1, 1, 0, 32'hFFEE_DDCC);
      win_op(0, 0, 2, 0, 1, 1, 0, 32'h1122_3344);
      win_op(0, 0, 4, 0, 1, 1, 0, 32'h5566_7788); idle();

      cur_req = "R6";
      ptr_op(1, 0, 4, 32'h8000_00FC);
      win_op(0, 3, 4, 0, 1, 1, 0, 32'hAABB_CCDD);
      win_op(0, 2, 4, 0, 1, 1, 0, 32'hAABB_CCDD);
      win_op(0, 1, 4, 0, 1, 1, 0, 32'hAABB_CCDD);
      ptr_op(1, 0, 4, 32'h8000_00F0);
      win_op(0, 0, 7, 0, 1, 1, 0, 32'h9988_7766);
      win_op(1, 0, 5, 32'h1357_9BDF, 1, 1, 0, 0); idle();

      cur_req = "R7";
      ptr_op(1, 0, 4, 32'h8002_0810);
      win_op(0, 0, 4, 0, 0, 1, 0, 32'h1111_2222);
      win_op(1, 0, 4, 32'h3333_4444, 0, 1, 0, 0); idle();

      cur_req = "R8";
      ptr_op(1, 0, 4, 32'h8002_0A10);
      win_op(0, 0, 4, 0, 1, 0, 1, 32'h7777_8888);
      win_op(1, 0, 4, 32'h1234_0000, 1, 0, 1, 0);
      win_op(0, 0, 4, 0, 1, 1, 1, 32'h7777_8888);
      ptr_op(1, 0, 4, 32'h8002_0810);
      win_op(0, 0, 4, 0, 1, 0, 1, 32'h6666_5555);
      win_op(1, 0, 4, 32'h4321_0000, 1, 0, 1, 0); idle();

      cur_req = "R10";
      win_op(1, 0, 2, 32'h0000_BEEF, 1, 1, 0, 0);
      win_op(1, 0, 2, 32'h0000_BEEF, 0, 0, 0, 0);
      ptr_op(1, 0, 4, 32'h0002_0810);
      win_op(1, 0, 2, 32'h0000_BEEF, 1, 1, 0, 0); idle();
      idle(); idle();

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule